// File: doc/BRIEF.md
# Dual-Domain Clock Mode Sequencer

This block steers a clock generator between operating modes that are selected by two enables, one for the host-interface clock domain and one for the core (power-management controller) domain. From the requested mode it drives an oscillator frequency select, a pre-scaler value and the gate enables of the host and core clocks. No gate opens before the frequency multiplier reports that it is stable. That stable indication comes in asynchronously and passes through a synchronizer first.

Mode changes are not instant. When the host enable is removed while both domains are running, the core clock keeps its previous settings until firmware sends an apply command from its interrupt handler. When the core-only mode gains the host enable, the host clock stays gated until firmware loads new settings with the same apply command. When the host-only mode gains the core enable, the pre-scaler comes from a programmable register instead. Each edge of the host enable latches a sticky interrupt flag, and firmware clears these flags through a simple write port.

Top module: `clk_mode_ctrl`

## Requirements
- R1: `mode_status` is the registered copy of {core_en, host_en} and changes one clock after the enables change. The encoding is 00 off, 01 host-only, 10 core-only and 11 both.
- R2: On entry to host-only mode, `osc_sel` returns to 1 (the 96 MHz default) and `core_gate_en` is low. `host_gate_en` follows the synchronized stable indication.
- R3: `mult_stable_async` passes through a two-flop synchronizer. A gate opens or closes on the second rising clock edge after the input changes, and never on the first.
- R4: On a change from host-only to both-enabled, `osc_sel` becomes 1 and `prescale` takes the value of the pre-scaler register. That register is written at address 0 with data bits [PW-1:0].
- R5: On a change from core-only to both-enabled, `host_gate_en` stays low and `osc_sel`/`prescale` stay unchanged until an apply command arrives. The apply command is a write to address 2, with bit PW carrying `osc_sel` and bits [PW-1:0] carrying `prescale`. The command loads both values, and the host gate may then open.
- R6: On a change from both-enabled to core-only, `host_gate_en` closes and `core_gate_en` stays open. `osc_sel` and `prescale` keep their previous values until an apply command loads new ones.
- R7: An apply command that arrives while no handshake is pending has no effect on `osc_sel` or `prescale`.
- R8: A rising edge of the host enable sets `irq_flags[0]` and a falling edge sets `irq_flags[1]`. `irq` is the OR of both flags.
- R9: The flags are sticky. A write to address 1 clears each flag whose data bit is 1. A set in the same cycle wins over the clear.
- R10: `core_gate_en` equals the synchronized stable indication in core-only and both-enabled modes. In off mode both gates are low.
- R11: After reset, `mode_status` is 00, `osc_sel` is 1, `prescale` is PRESC_DEF (24 by default), the flags are 0 and both gates are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_en | input | 1 | Host-interface domain enable |
| core_en | input | 1 | Core domain enable |
| mult_stable_async | input | 1 | Frequency multiplier stable, asynchronous |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address: 0 pre-scaler register, 1 flag clear, 2 apply |
| wr_data | input | PW+1 | Write data |
| osc_sel | output | 1 | Oscillator select, 1 = 96 MHz default |
| prescale | output | PW | Active pre-scaler value |
| host_gate_en | output | 1 | Host clock gate enable |
| core_gate_en | output | 1 | Core clock gate enable |
| irq | output | 1 | Interrupt request to the core |
| irq_flags | output | 2 | Sticky flags: bit 0 host enable rose, bit 1 host enable fell |
| mode_status | output | 2 | Current mode |

## Verification
The hardest state to reach is a pending handshake that must survive other traffic. The bench first runs both domains, drops the host enable, and answers that handshake with an apply. A second apply then arrives with nothing pending and has to be ignored. After that the bench raises the host enable again from core-only mode and holds the host gate shut for several cycles before loading new settings. A clear write placed in the same cycle as a host-enable edge tests the set-over-clear rule. Removing the stable input while the gates are open shows the two-edge synchronizer delay in both directions.

// File: rtl/clkmode_pkg.sv
package clkmode_pkg;
   typedef enum logic [1:0] {
      MODE_OFF  = 2'b00,
      MODE_HOST = 2'b01,
      MODE_CORE = 2'b10,
      MODE_BOTH = 2'b11
   } mode_e;

   localparam logic [1:0] ADDR_PRESC = 2'd0;
   localparam logic [1:0] ADDR_CLR   = 2'd1;
   localparam logic [1:0] ADDR_APPLY = 2'd2;
endpackage

// File: rtl/clkmode_sync.sv
module clkmode_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d};
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/clkmode_seq.sv
module clkmode_seq
   import clkmode_pkg::*;
#(
   parameter int   PW        = 5,
   parameter int   PRESC_DEF = 24,
   parameter logic OSC_DEF   = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  mode_e         req,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [PW:0]   wr_data,
   output mode_e         mode_q,
   output logic          osc_q,
   output logic [PW-1:0] presc_q,
   output logic          load_pend
);
   localparam logic [PW-1:0] PRESC_INIT = PW'(PRESC_DEF);

   logic [PW-1:0] presc_reg;
   logic          ack_pend;
   logic          apply_hit;

   assign apply_hit = wr_en && (wr_addr == ADDR_APPLY) && (load_pend || ack_pend);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q    <= MODE_OFF;
         osc_q     <= OSC_DEF;
         presc_q   <= PRESC_INIT;
         presc_reg <= PRESC_INIT;
         load_pend <= 1'b0;
         ack_pend  <= 1'b0;
      end else begin
         if (wr_en && (wr_addr == ADDR_PRESC)) presc_reg <= wr_data[PW-1:0];
         if (req != mode_q) begin
            mode_q    <= req;
            load_pend <= 1'b0;
            ack_pend  <= 1'b0;
            case (req)
               MODE_HOST: osc_q <= OSC_DEF;
               MODE_BOTH: begin
                  if (mode_q == MODE_CORE) begin
                     load_pend <= 1'b1;
                  end else begin
                     osc_q   <= OSC_DEF;
                     presc_q <= presc_reg;
                  end
               end
               MODE_CORE: if (mode_q == MODE_BOTH) ack_pend <= 1'b1;
               default: ;
            endcase
         end else if (apply_hit) begin
            osc_q     <= wr_data[PW];
            presc_q   <= wr_data[PW-1:0];
            load_pend <= 1'b0;
            ack_pend  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/clkmode_irq.sv
module clkmode_irq (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       host_req,
   input  logic       host_cur,
   input  logic       clr_en,
   input  logic [1:0] clr_bits,
   output logic [1:0] flags
);
   logic [1:0] set_v;
   logic [1:0] clr_v;

   assign set_v = {host_cur & ~host_req, host_req & ~host_cur};
   assign clr_v = clr_en ? clr_bits : 2'b00;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags <= 2'b00;
      else        flags <= (flags & ~clr_v) | set_v;
   end
endmodule

// File: rtl/clkmode_gate.sv
module clkmode_gate
   import clkmode_pkg::*;
(
   input  mode_e mode,
   input  logic  stable,
   input  logic  load_pend,
   output logic  host_gate,
   output logic  core_gate
);
   always_comb begin
      host_gate = 1'b0;
      core_gate = 1'b0;
      case (mode)
         MODE_HOST: host_gate = stable;
         MODE_CORE: core_gate = stable;
         MODE_BOTH: begin
            host_gate = stable && !load_pend;
            core_gate = stable;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
   import clkmode_pkg::*;
#(
   parameter int   PW          = 5,
   parameter int   PRESC_DEF   = 24,
   parameter logic OSC_DEF     = 1'b1,
   parameter int   SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          host_en,
   input  logic          core_en,
   input  logic          mult_stable_async,
   input  logic          wr_en,
   input  logic [1:0]    wr_addr,
   input  logic [PW:0]   wr_data,
   output logic          osc_sel,
   output logic [PW-1:0] prescale,
   output logic          host_gate_en,
   output logic          core_gate_en,
   output logic          irq,
   output logic [1:0]    irq_flags,
   output logic [1:0]    mode_status
);
   generate
      if (PW < 2) begin : g_pw_bad
         $error("PW must be at least 2");
      end
      if (PRESC_DEF < 0 || PRESC_DEF >= (1 << PW)) begin : g_def_bad
         $error("PRESC_DEF does not fit in PW bits");
      end
      if (SYNC_STAGES < 2) begin : g_sync_bad
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   mode_e req;
   mode_e mode_q;
   logic  stable_s;
   logic  load_pend;

   assign req = mode_e'({core_en, host_en});

   clkmode_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (mult_stable_async),
      .q     (stable_s)
   );

   clkmode_seq #(.PW(PW), .PRESC_DEF(PRESC_DEF), .OSC_DEF(OSC_DEF)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req       (req),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .mode_q    (mode_q),
      .osc_q     (osc_sel),
      .presc_q   (prescale),
      .load_pend (load_pend)
   );

   clkmode_irq u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .host_req (host_en),
      .host_cur (mode_q[0]),
      .clr_en   (wr_en && (wr_addr == ADDR_CLR)),
      .clr_bits (wr_data[1:0]),
      .flags    (irq_flags)
   );

   clkmode_gate u_gate (
      .mode      (mode_q),
      .stable    (stable_s),
      .load_pend (load_pend),
      .host_gate (host_gate_en),
      .core_gate (core_gate_en)
   );

   assign irq         = |irq_flags;
   assign mode_status = mode_q;
endmodule

// File: rtl/clk_mode_ctrl_chk.sv
module clk_mode_ctrl_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic       clk,
   input logic       rst_n,
   input logic       mult_stable_async,
   input logic       wr_en,
   input logic [1:0] wr_addr,
   input logic       clr_bit0,
   input logic       osc_sel,
   input logic       host_gate_en,
   input logic       core_gate_en,
   input logic [1:0] irq_flags,
   input logic [1:0] mode_status
);
   AST_HOST_MODE_CORE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_status == 2'b01) |-> (!core_gate_en && osc_sel)); // R2

   AST_OFF_GATES_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_status == 2'b00) |-> (!host_gate_en && !core_gate_en)); // R10

   AST_HOST_WAITS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_status) == 2'b10 && mode_status == 2'b11) |-> !host_gate_en); // R5

   AST_CORE_KEEPS_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(mode_status) == 2'b11 && mode_status == 2'b10) |-> (!host_gate_en && $stable(osc_sel))); // R6

   AST_RISE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_status[0]) |-> irq_flags[0]); // R8

   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flags[0] && !(wr_en && wr_addr == 2'd1 && clr_bit0)) |=> irq_flags[0]); // R9

   generate
      if (SYNC_STAGES == 2) begin : g_two_stage
         AST_GATE_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rst_n)
            (host_gate_en || core_gate_en) |-> $past(mult_stable_async, 2)); // R3
      end
   endgenerate
endmodule

bind clk_mode_ctrl clk_mode_ctrl_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk               (clk),
   .rst_n             (rst_n),
   .mult_stable_async (mult_stable_async),
   .wr_en             (wr_en),
   .wr_addr           (wr_addr),
   .clr_bit0          (wr_data[0]),
   .osc_sel           (osc_sel),
   .host_gate_en      (host_gate_en),
   .core_gate_en      (core_gate_en),
   .irq_flags         (irq_flags),
   .mode_status       (mode_status)
);

// File: tb/clk_mode_ctrl_test.sv
module clk_mode_ctrl_test;
   localparam int PW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          host_en = 1'b0;
   logic          core_en = 1'b0;
   logic          stab = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_addr = 2'd0;
   logic [PW:0]   wr_data = '0;
   logic          osc_sel;
   logic [PW-1:0] prescale;
   logic          host_gate_en;
   logic          core_gate_en;
   logic          irq;
   logic [1:0]    irq_flags;
   logic [1:0]    mode_status;

   int checks = 0;
   int errors = 0;
   bit done   = 0;

   always #4 clk = ~clk;

   clk_mode_ctrl uut (
      .clk(clk), .rst_n(rst_n), .host_en(host_en), .core_en(core_en),
      .mult_stable_async(stab), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .osc_sel(osc_sel), .prescale(prescale), .host_gate_en(host_gate_en),
      .core_gate_en(core_gate_en), .irq(irq), .irq_flags(irq_flags), .mode_status(mode_status)
   );

   // reference model
   int m_mode, m_osc, m_presc, m_preg, m_lp, m_ap, m_flags, m_s1, m_s2;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_mode = 0; m_osc = 1; m_presc = 24; m_preg = 24;
         m_lp = 0; m_ap = 0; m_flags = 0; m_s1 = 0; m_s2 = 0;
      end else begin
         int req, old_preg, setb, clrb;
         req = (core_en ? 2 : 0) + (host_en ? 1 : 0);
         old_preg = m_preg;
         setb = 0;
         if (host_en && (m_mode % 2) == 0) setb += 1;
         if (!host_en && (m_mode % 2) == 1) setb += 2;
         clrb = (wr_en && wr_addr == 2'd1) ? int'(wr_data[1:0]) : 0;
         m_flags = (m_flags & ~clrb & 3) | setb;
         if (wr_en && wr_addr == 2'd0) m_preg = int'(wr_data[PW-1:0]);
         if (req != m_mode) begin
            m_lp = 0; m_ap = 0;
            if (req == 1) m_osc = 1;
            else if (req == 3) begin
               if (m_mode == 2) m_lp = 1;
               else begin m_osc = 1; m_presc = old_preg; end
            end else if (req == 2 && m_mode == 3) m_ap = 1;
            m_mode = req;
         end else if (wr_en && wr_addr == 2'd2 && (m_lp || m_ap)) begin
            m_osc = int'(wr_data[PW]); m_presc = int'(wr_data[PW-1:0]);
            m_lp = 0; m_ap = 0;
         end
         m_s2 = m_s1;
         m_s1 = int'(stab);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !done) begin
         int hg, cg;
         hg = (m_s2 == 1 && (m_mode == 1 || (m_mode == 3 && m_lp == 0))) ? 1 : 0;
         cg = (m_s2 == 1 && m_mode >= 2) ? 1 : 0;
         chk("R1 mode_status", int'(mode_status), m_mode);
         chk("R2 osc_sel", int'(osc_sel), m_osc);
         chk("R4 prescale", int'(prescale), m_presc);
         chk("R3 host_gate_en", int'(host_gate_en), hg);
         chk("R10 core_gate_en", int'(core_gate_en), cg);
         chk("R8 irq_flags", int'(irq_flags), m_flags);
         chk("R9 irq", int'(irq), (m_flags != 0) ? 1 : 0);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [PW:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step(1);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errors, checks);
   endtask

   initial begin
      #(8 * 20000);
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      done = 1;
      summary();
      $finish;
   end

   initial begin
      step(2);
      // R11 reset state
      chk("R11 mode", int'(mode_status), 0);
      chk("R11 osc", int'(osc_sel), 1);
      chk("R11 prescale", int'(prescale), 24);
      chk("R11 flags", int'(irq_flags), 0);
      chk("R11 gates", int'({host_gate_en, core_gate_en}), 0);
      rst_n = 1'b1;
      stab = 1'b1;
      step(3);
      // R2 host-only
      host_en = 1'b1;
      step(1);
      chk("R2 host gate", int'(host_gate_en), 1);
      chk("R2 core gate low", int'(core_gate_en), 0);
      chk("R8 rise flag", int'(irq_flags), 1);
      // R4 host-only to both
      wr(2'd0, 6'd7);
      core_en = 1'b1;
      step(1);
      chk("R4 prescale from register", int'(prescale), 7);
      chk("R4 osc default", int'(osc_sel), 1);
      // R6 both to core-only
      host_en = 1'b0;
      step(1);
      chk("R6 host gate closed", int'(host_gate_en), 0);
      chk("R6 core gate open", int'(core_gate_en), 1);
      chk("R6 prescale held", int'(prescale), 7);
      step(3);
      chk("R6 still held", int'(prescale), 7);
      wr(2'd2, {1'b0, 5'd3});
      chk("R6 apply prescale", int'(prescale), 3);
      chk("R6 apply osc", int'(osc_sel), 0);
      // R7 apply ignored
      wr(2'd2, {1'b1, 5'd9});
      chk("R7 prescale unchanged", int'(prescale), 3);
      chk("R7 osc unchanged", int'(osc_sel), 0);
      // R5 core-only to both
      host_en = 1'b1;
      step(1);
      chk("R5 host gate held", int'(host_gate_en), 0);
      step(4);
      chk("R5 host gate still held", int'(host_gate_en), 0);
      chk("R5 prescale unchanged", int'(prescale), 3);
      wr(2'd2, {1'b1, 5'd12});
      chk("R5 load prescale", int'(prescale), 12);
      chk("R5 load osc", int'(osc_sel), 1);
      chk("R5 host gate open", int'(host_gate_en), 1);
      // R9 clear bit0, keep bit1
      chk("R9 both flags", int'(irq_flags), 3);
      wr(2'd1, 6'd1);
      chk("R9 clear bit0", int'(irq_flags), 2);
      wr(2'd1, 6'd2);
      chk("R9 clear bit1", int'(irq_flags), 0);
      // R9 set wins over clear
      host_en = 1'b0;
      wr(2'd1, 6'd2);
      chk("R9 set beats clear", int'(irq_flags), 2);
      chk("R8 irq output", int'(irq), 1);
      // R3 synchronizer delay
      stab = 1'b0;
      step(1);
      chk("R3 core gate after one edge", int'(core_gate_en), 1);
      step(1);
      chk("R3 core gate after two edges", int'(core_gate_en), 0);
      stab = 1'b1;
      step(1);
      chk("R3 reopen one edge", int'(core_gate_en), 0);
      step(1);
      chk("R3 reopen two edges", int'(core_gate_en), 1);
      // R10 off mode
      core_en = 1'b0;
      step(3);
      chk("R10 off gates", int'({host_gate_en, core_gate_en}), 0);
      core_en = 1'b1;
      step(1);
      chk("R10 core-only gate", int'(core_gate_en), 1);
      chk("R1 core-only mode", int'(mode_status), 2);
      step(2);
      done = 1;
      summary();
      $finish;
   end
endmodule